// File: doc/BRIEF.md
# Compound-Angle Twiddle Generator

This block returns the cosine and sine of 2*pi*k/N for one index k at a time, where N = 2^M_BITS. It does not keep a table of all N roots of unity. It keeps only M_BITS base rotations, one for each binary weight of k. Each base rotation is the unit vector at angle 2*pi*2^q/N. The base values are worked out at elaboration by repeated half-angle steps that start from the rotation by pi, so the ROM is a set of constants with no file behind it.

A request latches k. The controller then walks the bits of k one per clock, starting at the least significant bit. A clear bit only moves the scan on. The first set bit copies its base rotation straight into the accumulator. Every later set bit spends one extra clock to rotate the accumulator by its base entry, using the angle-sum identities. The accumulator is wider (Q1.22) than the result (Q1.14), so rounding error from the chained products stays well below one output LSB. When the scan ends, the accumulator is rounded to nearest and a one-cycle done strobe is raised. Latency therefore depends on how many bits of k are set. A typical user is an FFT address generator that needs twiddles in an order that is not sequential.

Top module: `twiddle_gen`

## Requirements
- R1: While reset is held and after it is released, done is 0 and cos_out and sin_out are 0.
- R2: For k = 0 the result is cos_out = 16384 (1.0 in Q1.14) and sin_out = 0, with no rotation step.
- R3: A k with a single set bit at position q returns that base rotation. For q = M_BITS-1 the result is exactly (-16384, 0). For q = M_BITS-2 it is exactly (0, 16384).
- R4: For every k, cos_out and sin_out are signed Q1.14 (14 fraction bits). Each is within 2 LSB of the true cos(2*pi*k/N) or sin(2*pi*k/N) times 16384.
- R5: done rises M_BITS + max(s-1,0) + 1 clock edges after the edge that accepts req, where s is the number of set bits in k.
- R6: done is high for exactly one cycle per accepted request.
- R7: req and k_idx are ignored while a request is in progress. The result and the latency are those of the k captured at acceptance.
- R8: For adjacent indices k and k+1 the output pairs differ.
- R9: cos_out and sin_out change only in the cycle in which done is high, and otherwise hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Start request, taken only when idle |
| k_idx | input | M_BITS | Root index k |
| cos_out | output | OUT_W | Cosine of 2*pi*k/N, signed Q1.14 |
| sin_out | output | OUT_W | Sine of 2*pi*k/N, signed Q1.14 |
| done | output | 1 | One-cycle strobe, result valid |

## Verification
The bench sweeps every index from 0 to N-1. For each one it compares the result against real-valued cosine and sine within two LSB, and it compares the measured latency against the set-bit count.

It gives particular attention to the following cases:
- k = 0, which takes no rotation. A design that defaulted the accumulator badly would give garbage here.
- The pi and pi/2 entries, where any sign or base-table error shows as an exact mismatch.
- Indices with one set bit, where a design that rotated on the first bit instead of loading it would be a cycle slow.
- All-ones indices, where a design with drift in the chained products would miss the tolerance.

A request held high with a changing index during a computation checks that a design which re-latched k would be caught by a wrong value or a wrong latency.

// File: rtl/twgen_pkg.sv
package twgen_pkg;

    localparam int DEF_M_BITS = 10;
    localparam int DEF_ACC_W  = 24;
    localparam int DEF_OUT_W  = 16;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_MUL  = 2'd2,
        ST_FIN  = 2'd3
    } twgen_state_e;

    // Integer square root of a non-negative 64-bit value (floor)
    function automatic longint isqrt64(input longint x_in);
        longint x;
        longint res;
        longint b;
        x   = x_in;
        res = 0;
        for (int i = 31; i >= 0; i--) begin
            b = longint'(1) <<< (2 * i);
            if (x >= res + b) begin
                x   = x - (res + b);
                res = (res >>> 1) + b;
            end else begin
                res = res >>> 1;
            end
        end
        return res;
    endfunction

    // Base rotation q of an m-bit index: cos or sin of 2*pi*2^q/2^m.
    // Starts from angle pi (q = m-1) and halves the angle down to q,
    // working at 30 fraction bits, then rounds to accw-2 fraction bits.
    function automatic longint base_val(input int m, input int q,
                                        input int accw, input bit want_sin);
        longint scale;
        longint c;
        longint s;
        longint v;
        int     sh;
        scale = longint'(1) <<< 30;
        c     = -scale;
        s     = 0;
        for (int i = m - 1; i > q; i--) begin
            s = isqrt64(((scale - c) / 2) * scale);
            c = isqrt64(((scale + c) / 2) * scale);
        end
        sh = 30 - (accw - 2);
        v  = want_sin ? s : c;
        return (v + (longint'(1) <<< (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/twgen_base_rom.sv
module twgen_base_rom
    import twgen_pkg::*;
#(
    parameter int M_BITS = DEF_M_BITS,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic [((M_BITS > 1) ? $clog2(M_BITS) : 1)-1:0] sel,
    output logic signed [ACC_W-1:0]                        base_c,
    output logic signed [ACC_W-1:0]                        base_s
);

    logic signed [ACC_W-1:0] tab_c [M_BITS];
    logic signed [ACC_W-1:0] tab_s [M_BITS];

    for (genvar q = 0; q < M_BITS; q++) begin : g_entry
        localparam longint CV = base_val(M_BITS, q, ACC_W, 1'b0);
        localparam longint SV = base_val(M_BITS, q, ACC_W, 1'b1);
        assign tab_c[q] = CV[ACC_W-1:0];
        assign tab_s[q] = SV[ACC_W-1:0];
    end

    assign base_c = tab_c[sel];
    assign base_s = tab_s[sel];

endmodule

// File: rtl/twgen_rotate.sv
module twgen_rotate
    import twgen_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic signed [ACC_W-1:0] a_c,
    input  logic signed [ACC_W-1:0] a_s,
    input  logic signed [ACC_W-1:0] b_c,
    input  logic signed [ACC_W-1:0] b_s,
    output logic signed [ACC_W-1:0] y_c,
    output logic signed [ACC_W-1:0] y_s
);

    localparam int FRAC = ACC_W - 2;
    localparam int SW   = 2 * ACC_W + 1;
    localparam logic signed [SW-1:0] RND = SW'(1) << (FRAC - 1);

    logic signed [2*ACC_W-1:0] p_cc, p_ss, p_sc, p_cs;
    logic signed [SW-1:0]      sum_c, sum_s;

    // cos(A+B) = cA*cB - sA*sB ; sin(A+B) = sA*cB + cA*sB
    always_comb begin
        p_cc  = a_c * b_c;
        p_ss  = a_s * b_s;
        p_sc  = a_s * b_c;
        p_cs  = a_c * b_s;
        sum_c = SW'(p_cc) - SW'(p_ss) + RND;
        sum_s = SW'(p_sc) + SW'(p_cs) + RND;
    end

    assign y_c = sum_c[FRAC +: ACC_W];
    assign y_s = sum_s[FRAC +: ACC_W];

    logic unused_rot_bits;
    assign unused_rot_bits = ^{sum_c[FRAC-1:0], sum_s[FRAC-1:0],
                               sum_c[SW-1:FRAC+ACC_W], sum_s[SW-1:FRAC+ACC_W]};

endmodule

// File: rtl/twgen_round.sv
module twgen_round
    import twgen_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] res
);

    localparam int SH = ACC_W - OUT_W;
    localparam logic signed [ACC_W:0] HALF = (ACC_W + 1)'(1) << (SH - 1);

    logic signed [ACC_W:0] biased;

    assign biased = (ACC_W + 1)'(acc) + HALF;
    assign res    = biased[SH +: OUT_W];

    logic unused_rnd_bits;
    assign unused_rnd_bits = ^{biased[SH-1:0], biased[ACC_W]};

endmodule

// File: rtl/twiddle_gen.sv
module twiddle_gen
    import twgen_pkg::*;
#(
    parameter int M_BITS = DEF_M_BITS,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int OUT_W  = DEF_OUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic [M_BITS-1:0]       k_idx,
    output logic signed [OUT_W-1:0] cos_out,
    output logic signed [OUT_W-1:0] sin_out,
    output logic                    done
);

    localparam int PW   = (M_BITS > 1) ? $clog2(M_BITS) : 1;
    localparam int FRAC = ACC_W - 2;
    localparam logic signed [ACC_W-1:0] ACC_ONE = ACC_W'(1) << FRAC;
    localparam logic [PW-1:0] LAST_POS = PW'(M_BITS - 1);

    twgen_state_e            state_q;
    logic [M_BITS-1:0]       k_q;
    logic [PW-1:0]           pos_q;
    logic                    have_q;
    logic signed [ACC_W-1:0] acc_c_q, acc_s_q;
    logic signed [OUT_W-1:0] cos_q, sin_q;
    logic                    done_q;

    logic signed [ACC_W-1:0] base_c, base_s;
    logic signed [ACC_W-1:0] rot_c, rot_s;
    logic signed [OUT_W-1:0] rnd_c, rnd_s;
    logic                    at_last;

    twgen_base_rom #(.M_BITS(M_BITS), .ACC_W(ACC_W)) u_rom (
        .sel    (pos_q),
        .base_c (base_c),
        .base_s (base_s)
    );

    twgen_rotate #(.ACC_W(ACC_W)) u_rot (
        .a_c (acc_c_q),
        .a_s (acc_s_q),
        .b_c (base_c),
        .b_s (base_s),
        .y_c (rot_c),
        .y_s (rot_s)
    );

    twgen_round #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rnd_c (
        .acc (acc_c_q),
        .res (rnd_c)
    );

    twgen_round #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rnd_s (
        .acc (acc_s_q),
        .res (rnd_s)
    );

    assign at_last = (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            pos_q   <= '0;
            have_q  <= 1'b0;
            acc_c_q <= ACC_ONE;
            acc_s_q <= '0;
            cos_q   <= '0;
            sin_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        k_q     <= k_idx;
                        pos_q   <= '0;
                        have_q  <= 1'b0;
                        acc_c_q <= ACC_ONE;
                        acc_s_q <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (k_q[pos_q] && have_q) begin
                        state_q <= ST_MUL;
                    end else begin
                        if (k_q[pos_q]) begin
                            acc_c_q <= base_c;
                            acc_s_q <= base_s;
                            have_q  <= 1'b1;
                        end
                        if (at_last) state_q <= ST_FIN;
                        else         pos_q   <= pos_q + PW'(1);
                    end
                end
                ST_MUL: begin
                    acc_c_q <= rot_c;
                    acc_s_q <= rot_s;
                    state_q <= ST_SCAN;
                    if (at_last) state_q <= ST_FIN;
                    else         pos_q   <= pos_q + PW'(1);
                end
                ST_FIN: begin
                    cos_q   <= rnd_c;
                    sin_q   <= rnd_s;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cos_out = cos_q;
    assign sin_out = sin_q;
    assign done    = done_q;

endmodule

// File: rtl/twgen_chk.sv
module twgen_chk
    import twgen_pkg::*;
#(
    parameter int M_BITS = DEF_M_BITS,
    parameter int OUT_W  = DEF_OUT_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req,
    input logic                    done,
    input logic signed [OUT_W-1:0] cos_out,
    input logic signed [OUT_W-1:0] sin_out,
    input twgen_state_e            state_q,
    input logic [M_BITS-1:0]       k_q
);

    localparam int LW = $clog2(2 * M_BITS + 4) + 1;
    localparam logic signed [OUT_W-1:0] OUT_ONE = OUT_W'(1) << (OUT_W - 2);

    logic [LW-1:0] lat_q;
    logic [LW-1:0] lat_exp;
    int            ones;

    always_ff @(posedge clk) begin
        if (rst)                                lat_q <= '0;
        else if (state_q == ST_IDLE && req)     lat_q <= '0;
        else if (state_q != ST_IDLE)            lat_q <= lat_q + LW'(1);
    end

    always_comb begin
        ones    = $countones(k_q);
        lat_exp = LW'(M_BITS + 1 + ((ones > 0) ? ones - 1 : 0));
    end

    // R5
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> lat_q == lat_exp);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cos_out) && $stable(sin_out)));

    // R7
    index_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(k_q));

    // R2
    zero_index_chk: assert property (@(posedge clk) disable iff (rst)
        (done && k_q == '0) |-> (cos_out == OUT_ONE && sin_out == '0));

endmodule

bind twiddle_gen twgen_chk #(.M_BITS(M_BITS), .OUT_W(OUT_W)) u_twgen_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .done    (done),
    .cos_out (cos_out),
    .sin_out (sin_out),
    .state_q (state_q),
    .k_q     (k_q)
);

// File: tb/test_twiddle_gen.sv
`timescale 1ns/1ps
module test_twiddle_gen;

    localparam int  M   = 10;
    localparam int  AW  = 24;
    localparam int  OW  = 16;
    localparam int  N   = 1 << M;
    localparam int  ONE = 1 << (OW - 2);
    localparam real PI  = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req = 1'b0;
    logic [M-1:0]         k_idx = '0;
    logic signed [OW-1:0] cos_out, sin_out;
    logic                 done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    twiddle_gen #(.M_BITS(M), .ACC_W(AW), .OUT_W(OW)) i_twiddle_gen (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .k_idx   (k_idx),
        .cos_out (cos_out),
        .sin_out (sin_out),
        .done    (done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_latency(input int kv);
        int s;
        s = $countones(kv[M-1:0]);
        return M + ((s > 0) ? s - 1 : 0) + 1;
    endfunction

    // Issue one request, count clock edges after acceptance until done
    task automatic run_k(input int kv, output int lat, output int rc, output int rs);
        @(negedge clk);
        k_idx = kv[M-1:0];
        req   = 1'b1;
        @(posedge clk);
        #1 req = 1'b0;
        lat = 0;
        while (1) begin
            @(posedge clk);
            #1;
            lat++;
            if (done || lat > 100) break;
        end
        rc = int'(cos_out);
        rs = int'(sin_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  lat, rc, rs, pc, ps;
        real ec, es;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs during reset
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(cos_out == '0, "R1 cos in reset", int'(cos_out), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && sin_out == '0, "R1 after reset", int'(sin_out), 0);

        // R2: zero index
        run_k(0, lat, rc, rs);
        check(rc == ONE, "R2 k=0 cos", rc, ONE);
        check(rs == 0, "R2 k=0 sin", rs, 0);
        check(lat == M + 1, "R2/R5 k=0 latency", lat, M + 1);

        // R3: exact quadrant entries
        run_k(1 << (M - 1), lat, rc, rs);
        check(rc == -ONE && rs == 0, "R3 angle pi cos", rc, -ONE);
        run_k(1 << (M - 2), lat, rc, rs);
        check(rc == 0 && rs == ONE, "R3 angle pi/2 sin", rs, ONE);

        // R7: request and index changes while busy are ignored
        @(negedge clk);
        k_idx = 10'd3;
        req   = 1'b1;
        @(posedge clk);
        #1 k_idx = '1;
        lat = 0;
        while (1) begin
            @(posedge clk);
            #1;
            lat++;
            if (lat == 3) req = 1'b0;
            if (done || lat > 100) break;
        end
        ec = $cos(2.0 * PI * 3.0 / real'(N)) * real'(ONE);
        check(lat == exp_latency(3), "R7 latency of captured k", lat, exp_latency(3));
        check((real'(cos_out) - ec) <= 2.0 && (ec - real'(cos_out)) <= 2.0,
              "R7 value of captured k", int'(cos_out), int'(ec));
        // R6: strobe lasts one cycle
        @(posedge clk);
        #1;
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);

        // R4, R5, R8, R3: sweep every index
        pc = 0;
        ps = 0;
        for (int kv = 0; kv < N; kv++) begin
            run_k(kv, lat, rc, rs);
            ec = $cos(2.0 * PI * real'(kv) / real'(N)) * real'(ONE);
            es = $sin(2.0 * PI * real'(kv) / real'(N)) * real'(ONE);
            check((real'(rc) - ec) <= 2.0 && (ec - real'(rc)) <= 2.0,
                  $sformatf("R4 cos k=%0d", kv), rc, int'(ec));
            check((real'(rs) - es) <= 2.0 && (es - real'(rs)) <= 2.0,
                  $sformatf("R4 sin k=%0d", kv), rs, int'(es));
            check(lat == exp_latency(kv), $sformatf("R5 latency k=%0d", kv),
                  lat, exp_latency(kv));
            if (kv > 0)
                check(rc != pc || rs != ps, $sformatf("R8 distinct k=%0d", kv), rc, pc);
            if ($countones(kv) == 1)
                check((real'(rc) - ec) <= 2.0 && (ec - real'(rc)) <= 2.0,
                      $sformatf("R3 single bit k=%0d", kv), rc, int'(ec));
            pc = rc;
            ps = rs;
        end

        // R9: result holds while idle
        rc = int'(cos_out);
        repeat (5) @(posedge clk);
        #1;
        check(int'(cos_out) == rc, "R9 hold while idle", int'(cos_out), rc);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule